// File: doc/BRIEF.md
# Sequential Nibble-Memory Host Port with Prefetch

This block puts a whole local buffer memory of up to 64 KB behind a single host data register. The host loads a byte start address once and then reads or writes the port over and over. Each access moves an internal byte pointer forward, and the pointer wraps from the top of the space back to zero.

Behind the port sits a memory that is only 4 bits wide. It is modelled as a synchronous nibble memory: a request is taken on a clock edge, and read data comes back on the next edge. On the read side, the block keeps a four-nibble window filled from the pointer, so a full host word is usually ready before the host asks for it. If the host asks too early, it gets wait states. On the write side, the block takes the host word in one cycle and writes it out one nibble at a time, lowest nibble first. A busy flag stays high while those nibble writes are in progress.

The host can make byte or 16-bit accesses. It may also use a wide mode, in which a doubleword access is split over two register pairs. A second requester inside the chip (a DMA engine) can take the memory through a simple grant.

Top module: `nibble_port`

## Requirements
- R1: While reset is low and just after it, `host_ready`, `wr_busy` and `dma_gnt` are low and the byte pointer is 0.
- R2: Register indices 12 and 13 always reach the port. Indices 14 and 15 reach it only while `wide_en` is 1. A request to any other index gets no `host_ready` and does not move the pointer.
- R3: An accepted byte access (`host_size`=0) adds 1 to the pointer, and an accepted word access (`host_size`=1) adds 2. The pointer wraps from 0xFFFF to 0x0000.
- R4: Byte address A maps to nibble addresses 2A (bits 3:0) and 2A+1 (bits 7:4). A word read at A returns byte A in bits 7:0 and byte A+1 in bits 15:8. A byte read returns byte A in bits 7:0 with bits 15:8 zero.
- R5: After a pointer load, with no write pending and no DMA grant, the block fetches four nibbles, one per cycle. A waiting word read is accepted no later than the sixth clock edge after the load edge.
- R6: A pointer load discards all prefetched and in-flight read data, even when a prefetch is still running. The next read returns data from the new address.
- R7: A read is held with `host_ready` low until every nibble it needs is in the window. It never returns stale data.
- R8: An accepted write stores the word (4 nibbles) or the byte (2 nibbles; `host_wdata[15:8]` ignored) at ascending nibble addresses, lowest nibble first. `wr_busy` is high from the cycle after acceptance until the last nibble is issued.
- R9: While `wr_busy` is high, port accesses wait. A read made after a write returns memory contents that already include the write.
- R10: In wide mode, a word access at index 12 followed by one at index 14 covers four consecutive bytes. Byte accesses at indices 12, 13, 14 and 15 also cover four consecutive bytes.
- R11: `dma_gnt` rises only when `dma_req` is high and the port has no nibble operation waiting. It stays high while `dma_req` stays high. `mem_req` is never high while `dma_gnt` is high.
- R12: A pointer load in the same cycle as a host request takes priority, and the host request is not accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, held until `host_ready` |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_size | input | 1 | 0 = byte, 1 = 16-bit word |
| host_reg | input | 4 | Register index within the block's IO window |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid while `host_ready` is high on a read |
| host_ready | output | 1 | Access is accepted at the next clock edge |
| wide_en | input | 1 | Enables indices 14 and 15 as port aliases (32-bit mode) |
| ptr_load | input | 1 | Load the byte pointer |
| ptr_value | input | 16 | New byte pointer value |
| wr_busy | output | 1 | Nibble writes still pending |
| dma_req | input | 1 | Internal DMA asks for the memory |
| dma_gnt | output | 1 | Memory granted to the DMA |
| mem_req | output | 1 | Nibble memory request |
| mem_we | output | 1 | Nibble memory write enable |
| mem_addr | output | 17 | Nibble address |
| mem_wdata | output | 4 | Nibble write data |
| mem_rdata | input | 4 | Nibble read data, one cycle after a read request |

## Verification
The bench uses these corner cases:
- **Load during a prefetch.** A design that kept in-flight nibbles across the load would return a mix of old and new addresses.
- **Odd start addresses and mixed byte/word reads.** A window that shifted by the wrong number of nibbles would return bytes out of order.
- **Wrap at the top of the space.** A design that did not wrap would read nibble 0x20000 instead of 0.
- **Read straight after a write.** A design that did not hold the read behind `wr_busy` would return old memory contents.
- **Alias registers with wide mode off.** A design that decoded indices 14 and 15 unconditionally would move the pointer.
- **DMA grant while the pointer is reloaded.** A design that let the prefetch through anyway would drive `mem_req` alongside the grant.

// File: rtl/nport_pkg.sv
`timescale 1ns/1ps
// Shared types for the nibble host port.
package nport_pkg;
    // Host access width as seen on host_size.
    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } host_size_e;
endpackage

// File: rtl/nport_arb.sv
`timescale 1ns/1ps
// Two-way memory arbiter between the port engine and an internal DMA.
// Assumes the DMA drives the memory on its own path while dma_gnt is high.
// The port engine wins whenever the DMA does not already own the memory.
// The DMA keeps ownership for as long as it requests.
module nport_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic eng_want,
    input  logic dma_req,
    output logic dma_gnt,
    output logic eng_go
);
    // Ownership register: the DMA takes the memory when the engine is idle, and holds it.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_gnt <= 1'b0;
        else        dma_gnt <= dma_req && (dma_gnt || !eng_want);
    end

    assign eng_go = eng_want && !dma_gnt;

    // R11
    dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && dma_req) |=> dma_gnt);
endmodule

// File: rtl/nport_prefetch.sv
`timescale 1ns/1ps
// Read window of NIBS nibbles that starts at the current pointer.
// It issues one fetch per cycle until the window plus the fetch in flight is full.
// A host read that is taken shifts consumed nibbles out of the window.
// A flush empties the window and drops any fetch still in flight.
// Assumes read data returns one cycle after the request.
module nport_prefetch #(
    parameter int NIB_W = 4,
    parameter int NIBS  = 4,
    parameter int NA_W  = 17,
    parameter int CNT_W = $clog2(NIBS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  blocked,
    input  logic                  go,
    input  logic [NA_W-1:0]       base_nib,
    input  logic [CNT_W-1:0]      take,
    input  logic [NIB_W-1:0]      mem_rdata,
    output logic                  want,
    output logic [NA_W-1:0]       fetch_addr,
    output logic [NIBS*NIB_W-1:0] word,
    output logic [CNT_W-1:0]      avail
);
    logic [NIB_W-1:0] buf_q [NIBS];
    logic [NIB_W-1:0] nbuf  [NIBS];
    logic [CNT_W-1:0] cnt_q, ncnt, fill;
    logic             infl_q;

    assign fill       = cnt_q + CNT_W'(infl_q);
    assign want       = !flush && !blocked && (fill < CNT_W'(NIBS));
    assign fetch_addr = base_nib + NA_W'(fill);
    assign avail      = cnt_q;

    generate
        for (genvar g = 0; g < NIBS; g++) begin : g_word
            assign word[g*NIB_W +: NIB_W] = buf_q[g];
        end
    endgenerate

    // Next window: shift out the consumed nibbles, then place a returning nibble.
    always_comb begin
        ncnt = cnt_q - take;
        for (int i = 0; i < NIBS; i++) begin
            if (i + int'(take) < NIBS) nbuf[i] = buf_q[i + int'(take)];
            else                       nbuf[i] = '0;
        end
        if (infl_q) begin
            for (int i = 0; i < NIBS; i++)
                if (CNT_W'(i) == ncnt) nbuf[i] = mem_rdata;
            ncnt = ncnt + CNT_W'(1);
        end
    end

    // Window state update; a flush empties it and cancels the fetch in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            infl_q <= 1'b0;
            for (int i = 0; i < NIBS; i++) buf_q[i] <= '0;
        end else if (flush) begin
            cnt_q  <= '0;
            infl_q <= 1'b0;
        end else begin
            cnt_q  <= ncnt;
            infl_q <= go && want;
            for (int i = 0; i < NIBS; i++) buf_q[i] <= nbuf[i];
        end
    end

    // R7
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(NIBS));
    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (avail == '0));
endmodule

// File: rtl/nport_wsplit.sv
`timescale 1ns/1ps
// Write splitter: holds one host word and writes it out as nibbles, lowest first.
// One nibble goes out on each cycle the arbiter lets the engine through.
// Assumes a load arrives only while no nibbles are still pending.
module nport_wsplit #(
    parameter int NIB_W = 4,
    parameter int NIBS  = 4,
    parameter int NA_W  = 17,
    parameter int CNT_W = $clog2(NIBS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [NIBS*NIB_W-1:0] ld_data,
    input  logic [CNT_W-1:0]      ld_nibs,
    input  logic [NA_W-1:0]       ld_addr,
    input  logic                  go,
    output logic                  want,
    output logic [NA_W-1:0]       nib_addr,
    output logic [NIB_W-1:0]      nib_data
);
    logic [NIBS*NIB_W-1:0] data_q;
    logic [NA_W-1:0]       addr_q;
    logic [CNT_W-1:0]      left_q;

    assign want     = (left_q != '0);
    assign nib_addr = addr_q;
    assign nib_data = data_q[NIB_W-1:0];

    // Capture a host write, then step through its nibbles as they are granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            data_q <= ld_data;
            addr_q <= ld_addr;
            left_q <= ld_nibs;
        end else if (go && want) begin
            data_q <= data_q >> NIB_W;
            addr_q <= addr_q + NA_W'(1);
            left_q <= left_q - CNT_W'(1);
        end
    end

    // R9
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !want);
    // R8
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> want);
endmodule

// File: rtl/nibble_port.sv
`timescale 1ns/1ps
// Host data port onto a nibble-wide buffer memory, with an auto-incrementing byte pointer.
// The port decodes its register indices, accepts host accesses, moves the pointer,
// and sends nibble traffic from the write splitter and the read prefetch window
// through the arbiter to the memory.
// Assumes 8-bit bytes made of whole nibbles, and a memory with one cycle of read latency.
module nibble_port
    import nport_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         NIB_W    = 4,
    parameter int         HOST_W   = 16,
    parameter logic [3:0] PORT_REG = 4'd12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  host_req,
    input  logic                                  host_wr,
    input  logic                                  host_size,
    input  logic [3:0]                            host_reg,
    input  logic [HOST_W-1:0]                     host_wdata,
    output logic [HOST_W-1:0]                     host_rdata,
    output logic                                  host_ready,
    input  logic                                  wide_en,
    input  logic                                  ptr_load,
    input  logic [ADDR_W-1:0]                     ptr_value,
    output logic                                  wr_busy,
    input  logic                                  dma_req,
    output logic                                  dma_gnt,
    output logic                                  mem_req,
    output logic                                  mem_we,
    output logic [ADDR_W+$clog2(8/NIB_W)-1:0]     mem_addr,
    output logic [NIB_W-1:0]                      mem_wdata,
    input  logic [NIB_W-1:0]                      mem_rdata
);
    localparam int BYTE_NIBS  = 8 / NIB_W;
    localparam int NIBS       = HOST_W / NIB_W;
    localparam int NA_W       = ADDR_W + $clog2(BYTE_NIBS);
    localparam int CNT_W      = $clog2(NIBS + 1);
    localparam int WORD_BYTES = HOST_W / 8;

    logic [ADDR_W-1:0]   ptr_q, step;
    logic                port_hit, is_word, flush;
    logic [CNT_W-1:0]    need, take;
    logic [NA_W-1:0]     base_nib, pf_addr, wr_addr;
    logic [HOST_W-1:0]   pf_word, ld_data;
    logic [CNT_W-1:0]    pf_avail;
    logic                pf_want, wr_want, eng_go;
    logic [NIB_W-1:0]    wr_nib;

    // Index 12 and 13 are always the port; 14 and 15 only in wide mode.
    assign port_hit = (host_reg == PORT_REG) || (host_reg == PORT_REG + 4'd1) ||
                      (wide_en && ((host_reg == PORT_REG + 4'd2) || (host_reg == PORT_REG + 4'd3)));
    assign is_word  = (host_size_e'(host_size) == SZ_WORD);
    assign need     = is_word ? CNT_W'(NIBS) : CNT_W'(BYTE_NIBS);
    assign step     = is_word ? ADDR_W'(WORD_BYTES) : ADDR_W'(1);

    assign host_ready = rst_n && host_req && port_hit && !ptr_load && !wr_busy &&
                        (host_wr || (pf_avail >= need));
    assign take       = (host_ready && !host_wr) ? need : '0;
    assign flush      = ptr_load || (host_ready && host_wr);
    assign base_nib   = NA_W'(ptr_q) * NA_W'(BYTE_NIBS);
    assign ld_data    = is_word ? host_wdata : {{(HOST_W-8){1'b0}}, host_wdata[7:0]};
    assign host_rdata = is_word ? pf_word : {{(HOST_W-8){1'b0}}, pf_word[7:0]};
    assign wr_busy    = wr_want;

    // Byte pointer: a load wins, otherwise an accepted access adds its size.
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr_q <= '0;
        else if (ptr_load)   ptr_q <= ptr_value;
        else if (host_ready) ptr_q <= ptr_q + step;
    end

    nport_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .eng_want (wr_want || pf_want),
        .dma_req  (dma_req),
        .dma_gnt  (dma_gnt),
        .eng_go   (eng_go)
    );

    nport_prefetch #(.NIB_W(NIB_W), .NIBS(NIBS), .NA_W(NA_W), .CNT_W(CNT_W)) u_pf (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .blocked    (wr_want),
        .go         (eng_go),
        .base_nib   (base_nib),
        .take       (take),
        .mem_rdata  (mem_rdata),
        .want       (pf_want),
        .fetch_addr (pf_addr),
        .word       (pf_word),
        .avail      (pf_avail)
    );

    nport_wsplit #(.NIB_W(NIB_W), .NIBS(NIBS), .NA_W(NA_W), .CNT_W(CNT_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (host_ready && host_wr),
        .ld_data  (ld_data),
        .ld_nibs  (need),
        .ld_addr  (base_nib),
        .go       (eng_go),
        .want     (wr_want),
        .nib_addr (wr_addr),
        .nib_data (wr_nib)
    );

    // Memory side: pending writes go before prefetch reads.
    assign mem_req   = eng_go;
    assign mem_we    = wr_want;
    assign mem_addr  = wr_want ? wr_addr : pf_addr;
    assign mem_wdata = wr_nib;

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> (ptr_q == $past(ptr_q) + $past(step)));
    // R2
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !port_hit && !ptr_load) |=> (ptr_q == $past(ptr_q)));
    // R11
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_gnt |-> !mem_req);
    // R9
    busy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && host_req) |-> !host_ready);
    // R12
    load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |-> !host_ready);
endmodule

// File: tb/nibble_port_tb.sv
`timescale 1ns/1ps
module nibble_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0, host_size = 1'b0;
    logic [3:0]  host_reg = 4'd12;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_ready;
    logic        wide_en = 1'b0;
    logic        ptr_load = 1'b0;
    logic [15:0] ptr_value = '0;
    logic        wr_busy;
    logic        dma_req = 1'b0;
    logic        dma_gnt;
    logic        mem_req, mem_we;
    logic [16:0] mem_addr;
    logic [3:0]  mem_wdata;
    logic [3:0]  mem_rdata;

    logic [3:0]  mem     [1024];
    logic [3:0]  exp_mem [1024];
    int n_chk = 0, n_fail = 0, mon_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nibble_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_size(host_size), .host_reg(host_reg), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .wide_en(wide_en),
        .ptr_load(ptr_load), .ptr_value(ptr_value), .wr_busy(wr_busy),
        .dma_req(dma_req), .dma_gnt(dma_gnt), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Nibble memory model, aliased on the low 10 address bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 4'(i * 7 + 3);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end
    end

    always @(negedge clk) if (rst_n && dma_gnt && mem_req) mon_bad++;

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        logic [9:0] n;
        n = {a[8:0], 1'b0};
        return {exp_mem[n + 10'd1], exp_mem[n]};
    endfunction

    function automatic logic [15:0] exp_word(input logic [15:0] a);
        return {exp_byte(a + 16'd1), exp_byte(a)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_ptr(input logic [15:0] a);
        @(negedge clk);
        ptr_load = 1'b1; ptr_value = a;
        @(negedge clk);
        ptr_load = 1'b0;
    endtask

    task automatic hacc(input logic wr, input logic word, input logic [3:0] rg,
                        input logic [15:0] wd, input int lim,
                        output logic [15:0] rd, output logic got, output int waits);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_size = word; host_reg = rg; host_wdata = wd;
        got = 1'b0; rd = '0; waits = 0;
        for (int i = 0; i < lim; i++) begin
            #1;
            if (host_ready) begin rd = host_rdata; got = 1'b1; break; end
            waits++;
            @(negedge clk);
        end
        if (got) begin @(posedge clk); @(negedge clk); end
        host_req = 1'b0;
    endtask

    task automatic rd_exp(input logic word, input logic [3:0] rg, input logic [15:0] exp, input string req);
        logic [15:0] rd; logic got; int w;
        hacc(1'b0, word, rg, 16'h0, 30, rd, got, w);
        chk(got, req, {31'd0, got}, 32'd1);
        chk(rd == exp, req, {16'd0, rd}, {16'd0, exp});
    endtask

    task automatic t_reset();
        host_req = 1'b1; host_reg = 4'd12;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(!host_ready && !wr_busy && !dma_gnt, "R1", {29'd0, host_ready, wr_busy, dma_gnt}, 32'd0);
        host_req = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_exp(1'b0, 4'd12, {8'h00, exp_byte(16'h0000)}, "R1");
    endtask

    task automatic t_latency();
        logic [15:0] rd; logic got; int w;
        load_ptr(16'h0040);
        hacc(1'b0, 1'b1, 4'd12, 16'h0, 30, rd, got, w);
        chk(got && w <= 6, "R5", w, 6);
        chk(w >= 2, "R7", w, 2);
        chk(rd == exp_word(16'h0040), "R4", rd, exp_word(16'h0040));
        rd_exp(1'b1, 4'd12, exp_word(16'h0042), "R3");
        rd_exp(1'b1, 4'd13, exp_word(16'h0044), "R3");
    endtask

    task automatic t_mixed();
        load_ptr(16'h0101);
        rd_exp(1'b0, 4'd12, {8'h00, exp_byte(16'h0101)}, "R4");
        rd_exp(1'b1, 4'd12, exp_word(16'h0102), "R4");
        rd_exp(1'b0, 4'd13, {8'h00, exp_byte(16'h0104)}, "R3");
        rd_exp(1'b0, 4'd12, {8'h00, exp_byte(16'h0105)}, "R3");
    endtask

    task automatic t_wrap();
        load_ptr(16'hFFFF);
        rd_exp(1'b1, 4'd12, {exp_byte(16'h0000), exp_byte(16'hFFFF)}, "R3");
        rd_exp(1'b0, 4'd12, {8'h00, exp_byte(16'h0001)}, "R3");
    endtask

    task automatic t_reload();
        @(negedge clk); ptr_load = 1'b1; ptr_value = 16'h0050;
        @(negedge clk); ptr_value = 16'h0058;
        @(negedge clk); ptr_load = 1'b0;
        rd_exp(1'b1, 4'd12, exp_word(16'h0058), "R6");
        // a host request made while a load is pending is not accepted in that cycle
        @(negedge clk); ptr_load = 1'b1; ptr_value = 16'h0060; host_req = 1'b1;
        host_wr = 1'b0; host_size = 1'b1; host_reg = 4'd12;
        #1; chk(!host_ready, "R12", {31'd0, host_ready}, 32'd0);
        @(negedge clk); ptr_load = 1'b0; host_req = 1'b0;
        rd_exp(1'b1, 4'd12, exp_word(16'h0060), "R12");
    endtask

    task automatic t_write();
        logic [15:0] rd; logic got; int w;
        load_ptr(16'h0180);
        hacc(1'b1, 1'b1, 4'd12, 16'hA5C3, 30, rd, got, w);
        #1; chk(wr_busy, "R8", {31'd0, wr_busy}, 32'd1);
        exp_mem[10'h300] = 4'h3; exp_mem[10'h301] = 4'hC;
        exp_mem[10'h302] = 4'h5; exp_mem[10'h303] = 4'hA;
        hacc(1'b0, 1'b0, 4'd12, 16'h0, 30, rd, got, w);
        chk(got && w > 3, "R9", w, 4);
        chk(rd == {8'h00, exp_byte(16'h0182)}, "R9", rd, {8'h00, exp_byte(16'h0182)});
        chk({mem[10'h303], mem[10'h302], mem[10'h301], mem[10'h300]} == 16'hA5C3, "R8",
            {mem[10'h303], mem[10'h302], mem[10'h301], mem[10'h300]}, 32'hA5C3);
        load_ptr(16'h0184);
        hacc(1'b1, 1'b0, 4'd12, 16'hFF5A, 30, rd, got, w);
        repeat (6) @(negedge clk);
        exp_mem[10'h308] = 4'hA; exp_mem[10'h309] = 4'h5;
        chk({mem[10'h30A], mem[10'h309], mem[10'h308]} == {exp_mem[10'h30A], 8'h5A}, "R8",
            {mem[10'h30A], mem[10'h309], mem[10'h308]}, {exp_mem[10'h30A], 8'h5A});
        load_ptr(16'h0180);
        rd_exp(1'b1, 4'd12, 16'hA5C3, "R9");
        rd_exp(1'b1, 4'd12, exp_word(16'h0182), "R9");
        rd_exp(1'b0, 4'd12, 16'h005A, "R9");
        // window already full of old data, then overwritten and reloaded
        load_ptr(16'h0180);
        repeat (8) @(negedge clk);
        hacc(1'b1, 1'b0, 4'd12, 16'h0077, 30, rd, got, w);
        exp_mem[10'h300] = 4'h7; exp_mem[10'h301] = 4'h7;
        load_ptr(16'h0180);
        rd_exp(1'b0, 4'd12, 16'h0077, "R6");
    endtask

    task automatic t_wide();
        logic [15:0] rd; logic got; int w;
        wide_en = 1'b0;
        load_ptr(16'h0020);
        hacc(1'b0, 1'b1, 4'd14, 16'h0, 8, rd, got, w);
        chk(!got, "R2", {31'd0, got}, 32'd0);
        hacc(1'b0, 1'b0, 4'd5, 16'h0, 8, rd, got, w);
        chk(!got, "R2", {31'd0, got}, 32'd0);
        rd_exp(1'b1, 4'd12, exp_word(16'h0020), "R2");
        wide_en = 1'b1;
        load_ptr(16'h0030);
        rd_exp(1'b1, 4'd12, exp_word(16'h0030), "R10");
        rd_exp(1'b1, 4'd14, exp_word(16'h0032), "R10");
        for (int k = 0; k < 4; k++)
            rd_exp(1'b0, 4'(12 + k), {8'h00, exp_byte(16'(16'h0034 + k))}, "R10");
        wide_en = 1'b0;
    endtask

    task automatic t_dma();
        logic [15:0] rd; logic got; int w;
        load_ptr(16'h0060);
        repeat (8) @(negedge clk);
        dma_req = 1'b1;
        @(negedge clk); #1;
        chk(dma_gnt, "R11", {31'd0, dma_gnt}, 32'd1);
        load_ptr(16'h0070);
        hacc(1'b0, 1'b1, 4'd12, 16'h0, 6, rd, got, w);
        chk(!got, "R11", {31'd0, got}, 32'd0);
        #1; chk(dma_gnt, "R11", {31'd0, dma_gnt}, 32'd1);
        dma_req = 1'b0;
        rd_exp(1'b1, 4'd12, exp_word(16'h0070), "R11");
        chk(mon_bad == 0, "R11", mon_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) exp_mem[i] = 4'(i * 7 + 3);
        t_reset();
        t_latency();
        t_mixed();
        t_wrap();
        t_reload();
        t_write();
        t_wide();
        t_dma();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule